// File: doc/BRIEF.md
# Non-overlapping timed pattern output generator

This block drives a 16-bit parallel output pattern that steps forward on timer compare events. A free-running up-counter is compared against two registers. The period register sets how often a new pattern is applied. The margin register sets a guard point inside each period. A host writes the next pattern ahead of time, chooses which output bits may change, and loads an initial value straight into the output register before it starts the counter.

The outputs form four groups of four bits. A group in normal mode takes its new value in one step. A group in non-overlap mode drops the bits that must turn off at the period boundary. It raises the bits that must turn on only when the counter later reaches the margin. As a result, two adjacent output phases are never both driven high. Each margin event sets a sticky interrupt request, which tells the host to supply the next pattern.

Top module: `nov_pattern_gen`

## Requirements
- R1: After reset, `pat_out` is 0, `irq` is 0, the counter is stopped at 0, and all configuration registers are 0.
- R2: The counter advances only while bit 0 of the control register (address 0) is 1. While that bit is 0, the counter holds and the outputs do not change.
- R3: With period value P (address 1), the counter counts 0..P. A period event happens at the edge where the count is at or above P, and that edge clears the count. After a start from count 0, the first new pattern appears P+1 clock edges after the start write.
- R4: At a period event, each enabled bit of a normal-mode group takes its value from the next-data register (address 3). Bits 4g+3..4g form group g, and bit g of the mode register (address 5) set to 1 puts group g in non-overlap mode.
- R5: At a period event, an enabled bit of a non-overlap group whose next value is 0 clears at once. An enabled bit whose next value is 1 is set only at the next margin event. The margin event is the edge where the count equals the margin value M (address 2).
- R6: If M is greater than or equal to P, no margin event occurs. The interrupt request stays clear, and the pending 0-to-1 changes of non-overlap groups never appear.
- R7: A margin event sets `irq`. `irq` stays set until a write to address 7 with bit 0 equal to 1, and a margin event in the same cycle keeps it set.
- R8: Output bits whose bit in the enable register (address 4) is 0 keep their value at both events.
- R9: A write to address 6 loads the output register directly, and the value is visible after that clock edge.
- R10: The next-data value is sampled on the period-event edge itself. A next-data write that lands on that same edge, or any later edge, affects only the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period, 2 margin, 3 next data, 4 enable, 5 mode, 6 direct output, 7 interrupt clear) |
| wr_data | input | 16 | Register write data |
| pat_out | output | 16 | Pattern output register |
| irq | output | 1 | Sticky interrupt request set at the margin event |

## Verification
Some rules are checked by assertions on every cycle: the counter clears after a period event, the counter holds while stopped, no margin event happens when the margin is not below the period, `irq` is sticky, disabled bits never move, and non-overlap bits rise only at a margin event. Other behaviour needs the bench's scenarios. These are the exact cycle on which the first pattern appears, the values each mode produces, the missing rise when the margin is too large, and a next-data write that lands on the period edge. A behavioural reference model compares the bench against the design on every clock.

// File: rtl/nov_pkg.sv
package nov_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_PERIOD = 3'd1,
    ADR_MARGIN = 3'd2,
    ADR_NEXT   = 3'd3,
    ADR_ENABLE = 3'd4,
    ADR_MODE   = 3'd5,
    ADR_OUTPUT = 3'd6,
    ADR_ACK    = 3'd7
  } nov_addr_e;
endpackage

// File: rtl/nov_timebase.sv
module nov_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] margin,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_a,
  output logic             ev_b
);
  function automatic logic hit_period(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic hit_margin(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m,
                                      input logic [CNT_W-1:0] p);
    return (m < p) && (c == m);
  endfunction

  assign ev_b = run && hit_period(cnt, period);
  assign ev_a = run && hit_margin(cnt, margin, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (run)
      cnt <= ev_b ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/nov_regfile.sv
module nov_regfile
  import nov_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OUT_W  = 16,
  parameter int N_GRP  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_a,
  output logic              run,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  margin,
  output logic [OUT_W-1:0]  next_q,
  output logic [OUT_W-1:0]  en_q,
  output logic [N_GRP-1:0]  mode_q,
  output logic              load_out,
  output logic              irq
);
  logic ack_hit;

  assign load_out = wr_en && (wr_addr == ADR_OUTPUT);
  assign ack_hit  = wr_en && (wr_addr == ADR_ACK) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      period <= '0;
      margin <= '0;
      next_q <= '0;
      en_q   <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL:   run    <= wr_data[0];
        ADR_PERIOD: period <= wr_data[CNT_W-1:0];
        ADR_MARGIN: margin <= wr_data[CNT_W-1:0];
        ADR_NEXT:   next_q <= wr_data[OUT_W-1:0];
        ADR_ENABLE: en_q   <= wr_data[OUT_W-1:0];
        ADR_MODE:   mode_q <= wr_data[N_GRP-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (ev_a)
      irq <= 1'b1;
    else if (ack_hit)
      irq <= 1'b0;
  end
endmodule

// File: rtl/nov_out_stage.sv
module nov_out_stage #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_a,
  input  logic             ev_b,
  input  logic [OUT_W-1:0] next_q,
  input  logic [OUT_W-1:0] en_q,
  input  logic [OUT_W-1:0] nov_bits,
  input  logic             load_out,
  input  logic [OUT_W-1:0] load_val,
  output logic [OUT_W-1:0] pat_out
);
  logic [OUT_W-1:0] pend_q;

  // value at the period event: disabled bits hold, normal bits copy,
  // non-overlap bits may only fall here
  function automatic logic [OUT_W-1:0] at_period(input logic [OUT_W-1:0] cur,
      input logic [OUT_W-1:0] nd, input logic [OUT_W-1:0] en, input logic [OUT_W-1:0] nov);
    return (cur & ~en) | (en & ~nov & nd) | (en & nov & nd & cur);
  endfunction

  function automatic logic [OUT_W-1:0] rises_later(input logic [OUT_W-1:0] nd,
      input logic [OUT_W-1:0] en, input logic [OUT_W-1:0] nov);
    return nd & en & nov;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pat_out <= '0;
    else if (load_out)
      pat_out <= load_val;
    else if (ev_b)
      pat_out <= at_period(pat_out, next_q, en_q, nov_bits);
    else if (ev_a)
      pat_out <= pat_out | pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (ev_b)
      pend_q <= rises_later(next_q, en_q, nov_bits);
    else if (ev_a)
      pend_q <= '0;
  end
endmodule

// File: rtl/nov_pattern_gen.sv
module nov_pattern_gen #(
  parameter int CNT_W = 16,
  parameter int N_GRP = 4,
  parameter int GRP_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] pat_out,
  output logic        irq
);
  localparam int OUT_W  = N_GRP * GRP_W;
  localparam int DATA_W = 16;

  logic             run;
  logic [CNT_W-1:0] period, margin, cnt;
  logic [OUT_W-1:0] next_q, en_q, nov_bits;
  logic [N_GRP-1:0] mode_q;
  logic             ev_a, ev_b, load_out;

  // group mode spread to bit positions
  for (genvar g = 0; g < N_GRP; g++) begin : g_mode
    assign nov_bits[g*GRP_W +: GRP_W] = en_q[g*GRP_W +: GRP_W] & {GRP_W{mode_q[g]}};
  end

  nov_regfile #(.CNT_W(CNT_W), .OUT_W(OUT_W), .N_GRP(N_GRP), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_a(ev_a), .run(run), .period(period), .margin(margin), .next_q(next_q),
    .en_q(en_q), .mode_q(mode_q), .load_out(load_out), .irq(irq)
  );

  nov_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period), .margin(margin),
    .cnt(cnt), .ev_a(ev_a), .ev_b(ev_b)
  );

  nov_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ev_a(ev_a), .ev_b(ev_b), .next_q(next_q),
    .en_q(en_q), .nov_bits(nov_bits), .load_out(load_out),
    .load_val(wr_data[OUT_W-1:0]), .pat_out(pat_out)
  );
endmodule

// File: rtl/nov_pattern_gen_chk.sv
module nov_pattern_gen_chk
  import nov_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] margin,
  input logic             ev_a,
  input logic             ev_b,
  input logic [OUT_W-1:0] en_q,
  input logic [OUT_W-1:0] nov_bits,
  input logic [OUT_W-1:0] pat_out,
  input logic             irq
);
  logic direct_wr, ack_wr;
  assign direct_wr = wr_en && (wr_addr == ADR_OUTPUT);
  assign ack_wr    = wr_en && (wr_addr == ADR_ACK) && wr_data[0];

  assert_clear_after_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> (cnt == '0));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  assert_no_margin_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (margin >= period) |-> !ev_a);

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a |=> irq);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq);

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_wr |=> (((pat_out ^ $past(pat_out)) & ~$past(en_q)) == '0));

  assert_late_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_a && !direct_wr) |=> (((pat_out & ~$past(pat_out)) & $past(nov_bits)) == '0));
endmodule

bind nov_pattern_gen nov_pattern_gen_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run), .cnt(cnt), .period(period), .margin(margin), .ev_a(ev_a), .ev_b(ev_b),
  .en_q(en_q), .nov_bits(nov_bits), .pat_out(pat_out), .irq(irq)
);

// File: tb/nov_pattern_gen_test.sv
module nov_pattern_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] pat_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nov_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pat_out(pat_out), .irq(irq)
  );

  // behavioural reference model
  bit          m_run;
  int          m_cnt, m_per, m_mar;
  logic [15:0] m_nd, m_en, m_out, m_pend;
  logic [3:0]  m_mode;
  bit          m_irq, m_evb_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_per = 0; m_mar = 0; m_nd = 0; m_en = 0;
      m_out = 0; m_pend = 0; m_mode = 0; m_irq = 0; m_evb_hit = 0;
    end else begin
      bit evb, eva;
      evb = m_run && (m_cnt >= m_per);
      eva = m_run && (m_mar < m_per) && (m_cnt == m_mar);
      m_evb_hit = evb;
      if (evb) begin
        m_pend = 0;
        for (int i = 0; i < 16; i++) begin
          if (m_en[i]) begin
            if (m_mode[i / 4]) begin
              if (!m_nd[i]) m_out[i] = 1'b0;
              else m_pend[i] = 1'b1;
            end else m_out[i] = m_nd[i];
          end
        end
      end else if (eva) begin
        m_out = m_out | m_pend;
        m_pend = 0;
      end
      if (eva) m_irq = 1;
      else if (wr_en && wr_addr == 3'd7 && wr_data[0]) m_irq = 0;
      if (m_run) m_cnt = evb ? 0 : m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_run = wr_data[0];
          3'd1: m_per = int'(wr_data);
          3'd2: m_mar = int'(wr_data);
          3'd3: m_nd = wr_data;
          3'd4: m_en = wr_data;
          3'd5: m_mode = wr_data[3:0];
          3'd6: m_out = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pat_out !== m_out || irq !== m_irq) begin
        errors++;
        $display("FAIL R3 R4 R5 R7 cycle model: pat_out=%h irq=%b expected %h %b",
                 pat_out, irq, m_out, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_b();
    do @(negedge clk); while (!m_evb_hit);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset output", pat_out, 16'h0000);
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);

    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'h0000);
    wr(3'd3, 16'h1234);
    wr(3'd6, 16'h00F0);
    chk("R9 direct load", pat_out, 16'h00F0);

    wr(3'd0, 16'h0001);
    n = 0;
    while (pat_out == 16'h00F0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R3 first pattern edge count", 16'(n), 16'd10);
    chk("R4 normal copy", pat_out, 16'h1234);
    chk("R7 irq after margin event", {15'd0, irq}, 16'h0001);
    wait_b();
    chk("R7 irq stays set", {15'd0, irq}, 16'h0001);
    wr(3'd7, 16'h0001);
    chk("R7 irq cleared by write", {15'd0, irq}, 16'h0000);

    wr(3'd4, 16'h00FF);
    wr(3'd3, 16'hABCD);
    wait_b();
    chk("R8 disabled bits hold", pat_out, 16'h12CD);

    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'h0001);
    wr(3'd3, 16'h12C2);
    wait_b();
    chk("R5 falling bits at period", pat_out, 16'h12C0);
    repeat (3) @(negedge clk);
    chk("R5 rise not before margin", pat_out, 16'h12C0);
    @(negedge clk);
    chk("R5 rise at margin", pat_out, 16'h12C2);

    wr(3'd2, 16'd12);
    wr(3'd7, 16'h0001);
    wr(3'd3, 16'h12CF);
    wait_b();
    wait_b();
    repeat (12) @(negedge clk);
    chk("R6 rises deferred", pat_out, 16'h12C2);
    chk("R6 no irq", {15'd0, irq}, 16'h0000);

    wr(3'd2, 16'd3);
    wr(3'd5, 16'h0000);
    wr(3'd3, 16'h5555);
    wait_b();
    chk("R10 setup", pat_out, 16'h5555);
    do @(negedge clk); while (m_cnt != m_per);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hAAAA;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 write on period edge not taken", pat_out, 16'h5555);
    wait_b();
    chk("R10 write taken next period", pat_out, 16'hAAAA);

    wr(3'd0, 16'h0000);
    cur = pat_out;
    wr(3'd3, 16'h0F0F);
    repeat (30) @(negedge clk);
    chk("R2 stopped output holds", pat_out, cur);
    chk("R2 stopped value", pat_out, 16'hAAAA);

    finish_run();
  end
endmodule